// File: doc/BRIEF.md
# Accumulating Read-Modify-Write Bus Master

This block is a bus master on the AXI4 read and write channels that keeps a running sum. Each accepted start pulse makes it fetch one data word from the address on its base-address input. It adds that word to an internal accumulator and then stores the new total back at the same address. The read and the write each use their own address phase and move exactly one data beat. The accumulator keeps its value from one invocation to the next and starts at zero after reset.

A controller drives `start` with an address while the block is idle. It then waits for the one-cycle `done` pulse. When `done` pulses, `resp_err` shows whether either response of that invocation was not OKAY. While the block is idle, `acc_clear` returns the running sum to zero. Only one channel is active at any time, so the block never has more than one transaction in flight.

Top module: `acc_rmw_master`

## Requirements
- R1: After reset, `busy`, `done`, `resp_err`, every valid and ready output and `acc_value` are all zero.
- R2: A `start` sampled while idle raises `m_arvalid` on the next cycle. `m_araddr` equals the sampled `base_addr`, `m_arlen` is 0, `m_arsize` is 2 (four-byte beats) and `m_arburst` is 2'b01 (incrementing). Valid and address hold steady until `m_arready`.
- R3: `m_rready` rises only in the cycle after the read address handshake. It falls after the single read beat, and at that beat the accumulator becomes old value plus `m_rdata`, modulo 2^32.
- R4: In the cycle after the read beat, `m_awvalid` and `m_wvalid` are both high. `m_awaddr` equals the address that was read, `m_awlen` is 0, `m_wdata` is the new sum, `m_wstrb` is all ones and `m_wlast` is 1. Each valid falls independently after its own handshake.
- R5: `m_bready` rises in the cycle after both the write address and the write data have been accepted. A write response handshake makes `done` high for exactly one cycle and `busy` low in that same cycle.
- R6: At most one of read address, read data, write request and write response is active in any cycle. A `start` seen while busy has no effect on the address or on the sequence.
- R7: `resp_err` is cleared by an accepted start. It is set if `m_rresp` or `m_bresp` of that invocation is not 2'b00 (OKAY). The sum is written back regardless.
- R8: `acc_clear` sampled while idle sets the accumulator to zero. Sampled while busy it is ignored.
- R9: The accumulator keeps its value between invocations, so successive reads add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one invocation (taken while idle) |
| base_addr | input | ADDR_W | Address to read and then write |
| acc_clear | input | 1 | Zero the accumulator (taken while idle) |
| busy | output | 1 | Invocation in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Non-OKAY response seen in last invocation |
| acc_value | output | DATA_W | Current accumulator |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read beat count minus one (0) |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write beat count minus one (0) |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The assertions assume the subordinate follows the protocol. It raises `m_rvalid` only after the read address has been taken and `m_bvalid` only after both write handshakes. It drives each valid for a single handshake cycle, and it keeps `m_rdata` steady while `m_rvalid` is high. The stimulus is generated inside one sequential task per invocation, so a response can only be offered once the block is waiting for it. Random ready delays of up to three cycles, random data and random response codes stay within these limits. Pulses of `start` and `acc_clear` sent while busy probe the ignore rules.

// File: rtl/acc_rmw_pkg.sv
package acc_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RDATA,
    ST_WREQ,
    ST_WRESP
  } seq_state_t;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/acc_rmw_seq.sv
module acc_rmw_seq
  import acc_rmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              arready,
  input  logic              rvalid,
  input  logic              awready,
  input  logic              wready,
  input  logic              bvalid,
  output logic [ADDR_W-1:0] addr,
  output logic              arvalid,
  output logic              rready,
  output logic              awvalid,
  output logic              wvalid,
  output logic              bready,
  output logic              done,
  output logic              idle,
  output logic              take,
  output logic              rd_beat,
  output logic              wr_ack
);
  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              arvalid_q, rready_q, awvalid_q, wvalid_q, bready_q, done_q;
  logic              aw_left, w_left;

  assign idle    = (state_q == ST_IDLE);
  assign take    = idle && start;
  assign rd_beat = rready_q && rvalid;
  assign wr_ack  = bready_q && bvalid;
  assign aw_left = awvalid_q && !awready;
  assign w_left  = wvalid_q && !wready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      arvalid_q <= 1'b0;
      rready_q  <= 1'b0;
      awvalid_q <= 1'b0;
      wvalid_q  <= 1'b0;
      bready_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          addr_q    <= base_addr;
          arvalid_q <= 1'b1;
          state_q   <= ST_RADDR;
        end
        ST_RADDR: if (arready) begin
          arvalid_q <= 1'b0;
          rready_q  <= 1'b1;
          state_q   <= ST_RDATA;
        end
        ST_RDATA: if (rvalid) begin
          rready_q  <= 1'b0;
          awvalid_q <= 1'b1;
          wvalid_q  <= 1'b1;
          state_q   <= ST_WREQ;
        end
        ST_WREQ: begin
          awvalid_q <= aw_left;
          wvalid_q  <= w_left;
          if (!aw_left && !w_left) begin
            bready_q <= 1'b1;
            state_q  <= ST_WRESP;
          end
        end
        ST_WRESP: if (bvalid) begin
          bready_q <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr    = addr_q;
  assign arvalid = arvalid_q;
  assign rready  = rready_q;
  assign awvalid = awvalid_q;
  assign wvalid  = wvalid_q;
  assign bready  = bready_q;
  assign done    = done_q;

  // R3: read data is accepted only after the address phase completed
  a_r3_rready_after_ar: assert property (@(posedge clk) disable iff (rst)
    $rose(rready_q) |-> $past(arvalid_q && arready));
  // R4: the write request follows the read beat
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(awvalid_q) |-> $past(rd_beat));
  // R6: no new address captured while busy
  a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(addr_q) || $past(idle));
endmodule

// File: rtl/acc_rmw_acc.sv
module acc_rmw_acc
  import acc_rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              take,
  input  logic              clear,
  input  logic              rd_beat,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              wr_ack,
  input  logic [1:0]        bresp,
  output logic [DATA_W-1:0] acc,
  output logic              err
);
  logic [DATA_W-1:0] acc_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (rd_beat) begin
      acc_q <= acc_q + rdata;
    end else if (clear && idle) begin
      acc_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (take) begin
      err_q <= 1'b0;
    end else if ((rd_beat && rresp != RESP_OKAY) || (wr_ack && bresp != RESP_OKAY)) begin
      err_q <= 1'b1;
    end
  end

  assign acc = acc_q;
  assign err = err_q;

  // R8: clear while idle empties the accumulator
  a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clear && idle |=> acc_q == '0);
  // R8: clear while busy leaves the sum untouched unless a beat arrives
  a_r8_clear_busy: assert property (@(posedge clk) disable iff (rst)
    !idle && !rd_beat |=> $stable(acc_q));
  // R7: the error flag stays set until the next accepted start
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q && !take |=> err_q);
endmodule

// File: rtl/acc_rmw_master.sv
module acc_rmw_master
  import acc_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic                acc_clear,
  output logic                busy,
  output logic                done,
  output logic                resp_err,
  output logic [DATA_W-1:0]   acc_value,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready
);
  localparam int         STRB_W = DATA_W / 8;
  localparam logic [2:0] SIZE_C = 3'($clog2(STRB_W));

  logic [ADDR_W-1:0] addr;
  logic              idle, take, rd_beat, wr_ack;

  acc_rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .base_addr(base_addr),
    .arready  (m_arready),
    .rvalid   (m_rvalid),
    .awready  (m_awready),
    .wready   (m_wready),
    .bvalid   (m_bvalid),
    .addr     (addr),
    .arvalid  (m_arvalid),
    .rready   (m_rready),
    .awvalid  (m_awvalid),
    .wvalid   (m_wvalid),
    .bready   (m_bready),
    .done     (done),
    .idle     (idle),
    .take     (take),
    .rd_beat  (rd_beat),
    .wr_ack   (wr_ack)
  );

  acc_rmw_acc #(.DATA_W(DATA_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .idle   (idle),
    .take   (take),
    .clear  (acc_clear),
    .rd_beat(rd_beat),
    .rdata  (m_rdata),
    .rresp  (m_rresp),
    .wr_ack (wr_ack),
    .bresp  (m_bresp),
    .acc    (acc_value),
    .err    (resp_err)
  );

  assign busy      = !idle;
  assign m_araddr  = addr;
  assign m_awaddr  = addr;
  assign m_arlen   = 8'd0;
  assign m_awlen   = 8'd0;
  assign m_arsize  = SIZE_C;
  assign m_awsize  = SIZE_C;
  assign m_arburst = BURST_INCR;
  assign m_awburst = BURST_INCR;
  assign m_wdata   = acc_value;
  assign m_wstrb   = {STRB_W{1'b1}};
  assign m_wlast   = 1'b1;

  // R2: read address held until accepted
  a_r2_ar_hold: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
  // R4: write data carries the sum of the previous total and the read beat
  a_r4_wdata_sum: assert property (@(posedge clk) disable iff (rst)
    $rose(m_wvalid) |-> m_wdata == $past(acc_value) + $past(m_rdata));
  // R5: done follows a write response handshake and lasts one cycle
  a_r5_done_after_b: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(m_bvalid && m_bready));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: a single channel active at a time
  a_r6_single_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m_arvalid, m_rready, m_awvalid || m_wvalid, m_bready}));
endmodule

// File: tb/tb_acc_rmw_master.sv
`timescale 1ns/1ps
module tb_acc_rmw_master;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, acc_clear = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic busy, done, resp_err;
  logic [DW-1:0] acc_value;
  logic [AW-1:0] m_araddr, m_awaddr;
  logic [7:0] m_arlen, m_awlen;
  logic [2:0] m_arsize, m_awsize;
  logic [1:0] m_arburst, m_awburst;
  logic m_arvalid, m_rready, m_awvalid, m_wvalid, m_wlast, m_bready;
  logic m_arready = 0, m_rvalid = 0, m_awready = 0, m_wready = 0, m_bvalid = 0;
  logic [DW-1:0] m_rdata = '0, m_wdata;
  logic [1:0] m_rresp = 2'b00, m_bresp = 2'b00;
  logic [DW/8-1:0] m_wstrb;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_acc = '0;

  always #2.5 clk = ~clk;

  acc_rmw_master #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  function automatic logic [DW-1:0] add_model(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic invoke(input logic [AW-1:0] addr, input logic [DW-1:0] rd,
                        input logic [1:0] rr, input logic [1:0] br,
                        input int ar_d, input int r_d, input int aw_d, input int w_d,
                        input bit poke);
    logic [DW-1:0] sum;
    int mx;
    sum = add_model(exp_acc, rd);
    mx = (aw_d > w_d) ? aw_d : w_d;
    @(negedge clk); base_addr = addr; start = 1'b1;
    @(negedge clk); start = 1'b0; base_addr = ~addr;
    chk("R2 arvalid", m_arvalid, 1);
    chk("R2 araddr", m_araddr, addr);
    chk("R2 arlen/size/burst", {m_arlen, m_arsize, m_arburst}, {8'd0, 3'd2, 2'b01});
    chk("R7 err cleared", resp_err, 0);
    for (int i = 0; i < ar_d; i++) begin
      if (poke) begin start = 1'b1; base_addr = addr ^ 32'h5a5a_0000; end
      @(negedge clk); start = 1'b0;
      chk("R2 ar held", {m_arvalid, m_rready}, 2'b10);
      chk("R6 addr unchanged by start", m_araddr, addr);
    end
    m_arready = 1'b1;
    @(negedge clk); m_arready = 1'b0;
    chk("R3 rready after ar", {m_arvalid, m_rready}, 2'b01);
    for (int i = 0; i < r_d; i++) begin
      if (poke) acc_clear = 1'b1;
      @(negedge clk); acc_clear = 1'b0;
      chk("R3 rready held", {m_rready, m_awvalid}, 2'b10);
    end
    m_rvalid = 1'b1; m_rdata = rd; m_rresp = rr;
    @(negedge clk); m_rvalid = 1'b0; m_rdata = $urandom; m_rresp = 2'b00;
    exp_acc = sum;
    chk("R3 rready drop", m_rready, 0);
    chk("R9 acc_value", acc_value, sum);
    chk("R4 aw/w valid", {m_awvalid, m_wvalid}, 2'b11);
    chk("R4 awaddr", m_awaddr, addr);
    chk("R4 wdata", m_wdata, sum);
    chk("R4 awlen/wlast/wstrb", {m_awlen, m_wlast, m_wstrb}, {8'd0, 1'b1, 4'hf});
    for (int c = 0; c <= 3; c++) begin
      m_awready = (c == aw_d);
      m_wready  = (c == w_d);
      @(negedge clk);
      chk("R4 awvalid drop", m_awvalid, (c < aw_d));
      chk("R4 wvalid drop", m_wvalid, (c < w_d));
      chk("R5 bready", m_bready, (c >= mx));
    end
    m_awready = 1'b0; m_wready = 1'b0;
    m_bvalid = 1'b1; m_bresp = br;
    @(negedge clk); m_bvalid = 1'b0; m_bresp = 2'b00;
    chk("R5 done", {done, busy, m_bready}, 3'b100);
    chk("R7 resp_err", resp_err, (rr != 2'b00) || (br != 2'b00));
    @(negedge clk);
    chk("R5 done pulse", done, 0);
    chk("R6 no extra read", m_arvalid, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {busy, done, resp_err, m_arvalid, m_rready, m_awvalid, m_wvalid, m_bready}, 8'd0);
    chk("R1 reset acc", acc_value, 0);

    // directed: wrap-around, error responses, zero delays, maximum delays
    invoke(32'h0000_1000, 32'hffff_fff0, 2'b00, 2'b00, 0, 0, 0, 0, 1'b0);
    invoke(32'h0000_1004, 32'h0000_0020, 2'b10, 2'b00, 3, 2, 3, 0, 1'b1);   // R3 wrap, R7 rresp
    invoke(32'h0000_1008, 32'h0000_0005, 2'b00, 2'b11, 1, 0, 0, 3, 1'b1);   // R7 bresp
    invoke(32'h0000_100c, 32'h0000_0001, 2'b00, 2'b00, 0, 1, 2, 2, 1'b0);   // R7 clears

    // R8: clear while idle
    @(negedge clk); acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0;
    chk("R8 clear idle", acc_value, 0);
    exp_acc = '0;

    for (int n = 0; n < 40; n++) begin
      logic [1:0] rr, br;
      rr = (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'b00;
      br = (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'b00;
      invoke($urandom & 32'hffff_fffc, $urandom, rr, br,
             int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
             1'($urandom % 2));
      if (($urandom % 8) == 0) begin
        @(negedge clk); acc_clear = 1'b1;
        @(negedge clk); acc_clear = 1'b0;
        exp_acc = '0;
        chk("R8 clear idle random", acc_value, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule